// File: doc/BRIEF.md
# Page Write-Lock Byte Gate

This block sits between a serial command decoder and the storage array of a user zone. It decides whether a byte write arriving from the host may reach the array. A zone can be set up so that each 8-byte page protects itself. The byte at the lowest address of the page is then the page's protection mask. When the zone is not set up this way, the block passes every byte of a command straight through to consecutive addresses.

A command opens with `cmd_start`, which carries the target address and the zone's mode. Data bytes then arrive one per `byte_vld` pulse, and `cmd_stop` closes the command. The block shows the address of the target byte and the address of its page's mask byte. The surrounding logic returns the stored values at those addresses on `cur_val` and `lock_val` in the same cycle. For each byte it produces one registered result, one cycle later. The result is either a write (`wr_en` with `wr_addr` and `wr_dat`) or a rejection pulse (`wr_rej`).

The controller has four states:
- IDLE: no command is open.
- LOCK_FIRST: a protected-zone command is waiting for its single data byte.
- LOCK_DROP: the byte has been used, and any further bytes of the command are dropped.
- OPEN: an unprotected command writes every byte.

Its transitions are:
- start_lock: IDLE or any state to LOCK_FIRST, on `cmd_start` with the mode set.
- start_open: IDLE or any state to OPEN, on `cmd_start` with the mode clear.
- take_first: LOCK_FIRST to LOCK_DROP, on a byte.
- open_byte: OPEN back to OPEN, on a byte, with the address advanced.
- stop: any state to IDLE, on `cmd_stop` without `cmd_start`.

`cmd_start` wins when it arrives in the same cycle as `cmd_stop`.

Top module: `lkg_gate`

## Requirements
- R1: After reset, `wr_en` and `wr_rej` are 0, and no byte produces a result until a command has been started.
- R2: With `cmd_lock_mode`=0, byte k of a command (counting from 0) is written one cycle after it arrives. Its address is the start address plus k, modulo the address range, and its value is the received byte unchanged. The protection mask is not consulted.
- R3: With `cmd_lock_mode`=1 and a target offset o = address bits [2:0] that is not 0, the byte is written unchanged to the target address when bit o of `lock_val` is 1.
- R4: With `cmd_lock_mode`=1, o not 0, and bit o of `lock_val` at 0, the byte is not written. Instead `wr_rej` pulses high for one cycle, one cycle after the byte arrives.
- R5: With `cmd_lock_mode`=1 and o = 0 (the mask byte itself), the write is permitted when bit 0 of `lock_val` is 1. The stored value is then `cur_val` AND the received byte, so bits can go from 1 to 0 and never from 0 to 1.
- R6: With `cmd_lock_mode`=1 and o = 0, a mask byte whose bit 0 is 0 is frozen: the write is rejected with `wr_rej`.
- R7: With `cmd_lock_mode`=1, only the first byte of a command produces a result. Later bytes of that command give neither `wr_en` nor `wr_rej`.
- R8: `lock_addr` equals the target address with bits [2:0] cleared, and `tgt_addr` equals the target address.
- R9: After `cmd_stop`, and before any command has been started, bytes produce neither `wr_en` nor `wr_rej`.
- R10: `wr_en` and `wr_rej` are never high in the same cycle, and each is high only in the cycle after a byte was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Opens a command |
| cmd_addr | input | ADDR_W | Target address of the command |
| cmd_lock_mode | input | 1 | 1 = zone uses per-page masks |
| cmd_stop | input | 1 | Closes the current command |
| byte_vld | input | 1 | A data byte is present |
| byte_dat | input | DATA_W | Data byte |
| lock_val | input | DATA_W | Stored value at `lock_addr` |
| cur_val | input | DATA_W | Stored value at `tgt_addr` |
| lock_addr | output | ADDR_W | Address of the page's mask byte |
| tgt_addr | output | ADDR_W | Address of the current target byte |
| wr_en | output | 1 | Write strobe to the array |
| wr_addr | output | ADDR_W | Write address |
| wr_dat | output | DATA_W | Write value |
| wr_rej | output | 1 | Write refused by the mask |

## Verification
The bench goes after the mask byte in both of its conditions.

If its bit 0 is still 1, a design that stores the raw new byte instead of the AND would let a cleared bit return to 1. The bench checks this with a new byte that has ones where the old mask has zeros. If bit 0 is 0, a design that tests the wrong bit would let the frozen mask change.

The bench also checks the following:
- Bit selection at several offsets, which a swapped or shifted index would fail.
- Extra bytes in a protected command, which a design that forgets the drop state would write.
- An unprotected command that crosses a page boundary, which a design that wraps at the page or consults the mask would break.
- Bytes sent outside any command or after a stop, which must leave the outputs quiet.

// File: rtl/lkg_pkg.sv
package lkg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LOCK_FIRST = 2'd1,
        ST_LOCK_DROP  = 2'd2,
        ST_OPEN       = 2'd3
    } lkg_state_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_WRITE  = 2'd1,
        ACT_REJECT = 2'd2
    } lkg_act_t;

endpackage

// File: rtl/lkg_addr_split.sv
module lkg_addr_split #(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] page_base,
    output logic [OFS_W-1:0]  page_ofs,
    output logic              is_base
);
    localparam int HI_W = ADDR_W - OFS_W;

    // Page base keeps the upper bits and zeroes the offset field.
    always_comb begin
        page_base = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        page_ofs  = addr[OFS_W-1:0];
        is_base   = (page_ofs == '0);
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = addr[ADDR_W-1:OFS_W];

endmodule

// File: rtl/lkg_permit.sv
module lkg_permit #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 3
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic              is_base,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    output logic              allow,
    output logic [DATA_W-1:0] store_val
);
    logic [DATA_W-1:0] sel;

    // One-hot decode of the page offset onto the mask bits.
    for (genvar i = 0; i < DATA_W; i++) begin : g_sel
        assign sel[i] = (ofs == i[OFS_W-1:0]);
    end

    always_comb begin
        allow = |(sel & mask);
        if (is_base) begin
            store_val = old_val & new_val;
        end else begin
            store_val = new_val;
        end
    end

endmodule

// File: rtl/lkg_fsm.sv
module lkg_fsm
    import lkg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_lock_mode,
    input  logic       cmd_stop,
    input  logic       byte_vld,
    output lkg_state_t st_q,
    output logic       take_lock,
    output logic       take_open
);
    lkg_state_t st_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        if (cmd_start) begin
            st_d = cmd_lock_mode ? ST_LOCK_FIRST : ST_OPEN;   // start_lock / start_open
        end else if (cmd_stop) begin
            st_d = ST_IDLE;                                     // stop
        end else begin
            unique case (st_q)
                ST_IDLE:       st_d = ST_IDLE;
                ST_LOCK_FIRST: st_d = byte_vld ? ST_LOCK_DROP : ST_LOCK_FIRST; // take_first
                ST_LOCK_DROP:  st_d = ST_LOCK_DROP;
                ST_OPEN:       st_d = ST_OPEN;                  // open_byte
                default:       st_d = ST_IDLE;
            endcase
        end
    end

    // Output decode: which kind of byte is consumed this cycle.
    always_comb begin
        take_lock = 1'b0;
        take_open = 1'b0;
        if (byte_vld && !cmd_start && !cmd_stop) begin
            unique case (st_q)
                ST_IDLE:       ;
                ST_LOCK_FIRST: take_lock = 1'b1;
                ST_LOCK_DROP:  ;
                ST_OPEN:       take_open = 1'b1;
                default:       ;
            endcase
        end
    end

endmodule

// File: rtl/lkg_gate.sv
module lkg_gate
    import lkg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_lock_mode,
    input  logic              cmd_stop,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_dat,
    input  logic [DATA_W-1:0] lock_val,
    input  logic [DATA_W-1:0] cur_val,
    output logic [ADDR_W-1:0] lock_addr,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_dat,
    output logic              wr_rej
);
    localparam int OFS_W = $clog2(DATA_W);

    lkg_state_t        st_q;
    logic              take_lock;
    logic              take_open;
    logic [ADDR_W-1:0] addr_q;
    logic [OFS_W-1:0]  ofs;
    logic              is_base;
    logic              allow;
    logic [DATA_W-1:0] store_val;
    lkg_act_t          act;

    lkg_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_start     (cmd_start),
        .cmd_lock_mode (cmd_lock_mode),
        .cmd_stop      (cmd_stop),
        .byte_vld      (byte_vld),
        .st_q          (st_q),
        .take_lock     (take_lock),
        .take_open     (take_open)
    );

    lkg_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_split (
        .addr      (addr_q),
        .page_base (lock_addr),
        .page_ofs  (ofs),
        .is_base   (is_base)
    );

    lkg_permit #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_permit (
        .ofs       (ofs),
        .is_base   (is_base),
        .mask      (lock_val),
        .old_val   (cur_val),
        .new_val   (byte_dat),
        .allow     (allow),
        .store_val (store_val)
    );

    assign tgt_addr = addr_q;

    // Target address: loaded at start, advanced per byte in open mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (cmd_start) begin
            addr_q <= cmd_addr;
        end else if (take_open) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    always_comb begin
        act = ACT_NONE;
        if (take_open) begin
            act = ACT_WRITE;
        end else if (take_lock) begin
            act = allow ? ACT_WRITE : ACT_REJECT;
        end
    end

    // Registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_rej  <= 1'b0;
            wr_addr <= '0;
            wr_dat  <= '0;
        end else begin
            wr_en  <= (act == ACT_WRITE);
            wr_rej <= (act == ACT_REJECT);
            if (act == ACT_WRITE) begin
                wr_addr <= addr_q;
                wr_dat  <= take_open ? byte_dat : store_val;
            end
        end
    end

endmodule

// File: rtl/lkg_gate_chk.sv
module lkg_gate_chk
    import lkg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic [DATA_W-1:0] byte_dat,
    input logic [DATA_W-1:0] lock_val,
    input logic [ADDR_W-1:0] lock_addr,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_dat,
    input logic              wr_rej,
    input lkg_state_t        st_q
);
    localparam int OFS_W = $clog2(DATA_W);

    // R10: write and reject are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_rej));

    // R10 / R9: a result needs a byte in the previous cycle
    a_r10_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || wr_rej) |-> $past(byte_vld));

    // R2: open-mode writes carry the byte unchanged
    a_r2_open_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(st_q) == ST_OPEN) |-> (wr_dat == $past(byte_dat)));

    // R5: a mask-byte write never sets a bit that was clear
    a_r5_mask_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(st_q) == ST_LOCK_FIRST && wr_addr[OFS_W-1:0] == '0)
            |-> ((wr_dat & ~$past(lock_val)) == '0));

    // R7: nothing comes out of the drop state
    a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_LOCK_DROP) |-> (!wr_en && !wr_rej));

    // R4: rejections only in a protected command
    a_r4_reject_lock_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rej |-> ($past(st_q) == ST_LOCK_FIRST));

    // R8: mask address shares the page of the target
    a_r8_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_addr[OFS_W-1:0] == '0) &&
        (lock_addr[ADDR_W-1:OFS_W] == tgt_addr[ADDR_W-1:OFS_W]));

endmodule

bind lkg_gate lkg_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_dat  (byte_dat),
    .lock_val  (lock_val),
    .lock_addr (lock_addr),
    .tgt_addr  (tgt_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_dat    (wr_dat),
    .wr_rej    (wr_rej),
    .st_q      (st_q)
);

// File: tb/lkg_gate_tb.sv
`timescale 1ns/1ps
module lkg_gate_tb;
    localparam int AW = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_lock_mode = 1'b0;
    logic          cmd_stop = 1'b0;
    logic          byte_vld = 1'b0;
    logic [DW-1:0] byte_dat = '0;
    logic [DW-1:0] lock_val;
    logic [DW-1:0] cur_val;
    logic [AW-1:0] lock_addr;
    logic [AW-1:0] tgt_addr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_dat;
    logic          wr_rej;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lkg_gate #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_lock_mode(cmd_lock_mode), .cmd_stop(cmd_stop), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .lock_val(lock_val), .cur_val(cur_val),
        .lock_addr(lock_addr), .tgt_addr(tgt_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_dat(wr_dat), .wr_rej(wr_rej)
    );

    // Array model
    assign lock_val = mem[lock_addr];
    assign cur_val  = mem[tgt_addr];
    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_dat;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [AW-1:0] a, input bit lk);
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = a; cmd_lock_mode = lk;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic stop_cmd();
        @(negedge clk);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
    endtask

    // Drives one byte; on return the registered result is visible.
    task automatic send_byte(input logic [DW-1:0] d);
        @(negedge clk);
        byte_vld = 1'b1; byte_dat = d;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk(wr_en === 1'b1, req, "wr_en", int'(wr_en), 1);
        chk(wr_rej === 1'b0, req, "wr_rej", int'(wr_rej), 0);
        chk(wr_addr === a, req, "wr_addr", int'(wr_addr), int'(a));
        chk(wr_dat === d, req, "wr_dat", int'(wr_dat), int'(d));
    endtask

    task automatic expect_reject(input string req);
        chk(wr_en === 1'b0, req, "wr_en", int'(wr_en), 0);
        chk(wr_rej === 1'b1, req, "wr_rej", int'(wr_rej), 1);
    endtask

    task automatic expect_quiet(input string req);
        chk(wr_en === 1'b0, req, "wr_en", int'(wr_en), 0);
        chk(wr_rej === 1'b0, req, "wr_rej", int'(wr_rej), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_quiet("R1");
        rst_n = 1'b1;
        send_byte(8'h77);
        expect_quiet("R1");
    endtask

    task automatic t_addr();
        start_cmd(10'h2AD, 1'b1);
        chk(lock_addr === 10'h2A8, "R8", "lock_addr", int'(lock_addr), 'h2A8);
        chk(tgt_addr === 10'h2AD, "R8", "tgt_addr", int'(tgt_addr), 'h2AD);
        stop_cmd();
    endtask

    task automatic t_open();
        mem[10'h1F8] = 8'h00;
        mem[10'h200] = 8'h00;
        start_cmd(10'h1FE, 1'b0);
        send_byte(8'hA1); expect_write("R2", 10'h1FE, 8'hA1);
        send_byte(8'hB2); expect_write("R2", 10'h1FF, 8'hB2);
        send_byte(8'hC3); expect_write("R2", 10'h200, 8'hC3);
        stop_cmd();
    endtask

    task automatic t_lock_bits();
        mem[10'h080] = 8'b1101_1001;
        mem[10'h083] = 8'h00;
        start_cmd(10'h083, 1'b1);
        send_byte(8'h5A); expect_write("R3", 10'h083, 8'h5A);
        stop_cmd();
        start_cmd(10'h087, 1'b1);
        send_byte(8'h3C); expect_write("R3", 10'h087, 8'h3C);
        stop_cmd();
        start_cmd(10'h082, 1'b1);
        send_byte(8'h11); expect_reject("R4");
        @(negedge clk); expect_quiet("R4");
        stop_cmd();
        start_cmd(10'h085, 1'b1);
        send_byte(8'h22); expect_reject("R4");
        stop_cmd();
    endtask

    task automatic t_mask_byte();
        mem[10'h100] = 8'h0F;
        start_cmd(10'h100, 1'b1);
        send_byte(8'hF3); expect_write("R5", 10'h100, 8'h03);
        stop_cmd();
        @(negedge clk);
        chk(mem[10'h100] === 8'h03, "R5", "stored mask", int'(mem[10'h100]), 'h03);
        start_cmd(10'h100, 1'b1);
        send_byte(8'hFE); expect_write("R5", 10'h100, 8'h02);
        stop_cmd();
        @(negedge clk);
        start_cmd(10'h100, 1'b1);
        send_byte(8'hFF); expect_reject("R6");
        stop_cmd();
        // offset 1 still governed by bit 1 (set)
        start_cmd(10'h101, 1'b1);
        send_byte(8'h66); expect_write("R6", 10'h101, 8'h66);
        stop_cmd();
    endtask

    task automatic t_drop();
        mem[10'h0C0] = 8'hFF;
        start_cmd(10'h0C4, 1'b1);
        send_byte(8'h11); expect_write("R7", 10'h0C4, 8'h11);
        send_byte(8'h22); expect_quiet("R7");
        send_byte(8'h33); expect_quiet("R7");
        stop_cmd();
        @(negedge clk);
        chk(mem[10'h0C4] === 8'h11, "R7", "stored byte", int'(mem[10'h0C4]), 'h11);
        chk(mem[10'h0C5] === 8'h00, "R7", "next byte", int'(mem[10'h0C5]), 'h00);
    endtask

    task automatic t_outside();
        stop_cmd();
        send_byte(8'h44); expect_quiet("R9");
        start_cmd(10'h300, 1'b0);
        stop_cmd();
        send_byte(8'h55); expect_quiet("R9");
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        t_reset();
        t_addr();
        t_open();
        t_lock_bits();
        t_mask_byte();
        t_drop();
        t_outside();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule